// File: doc/BRIEF.md
# Field-Sequenced Display Timing Generator

This block produces horizontal sync, vertical sync, data enable and pixel coordinates for a parallel pixel output. It supports progressive scan, interlaced scan, frame-packed stereo and interlaced stereo. A horizontal register group sets the line shape. Four vertical register groups, one for each field kind (left-odd, left-even, right-odd, right-even), set the shape of each field. Two mode bits choose which of these fields are visited and in what order.

Software writes the registers through a simple write-only parallel port. It programs the timing while the soft reset bit is set, then clears that bit with enable set, and generation starts at field 0. The active height register holds the lines of one field, so in interlaced modes it is half the frame height. The block latches timing values only at a field start. A write made in the middle of a field therefore cannot tear the picture. An even field can have its vertical sync edges moved by half a line, which is how interlaced fields are told apart.

Top module: `field_timing_gen`

## Requirements
- R1: Register 0 is the control word. Bit 0 is soft reset and resets to 1. Bit 1 is enable. While bit 0 is 1 or bit 1 is 0, the generator sits idle at field 0, line 0, column 0. In that state DE, HSYNC and VSYNC are deasserted, px_x, px_y and sof_o are 0, and it reaches this state on the second clock edge after the write at the latest.
- R2: Registers 1 to 4 hold, in that order, the horizontal sync width, back porch, active width and front porch. A line lasts the sum of these four in clocks. HSYNC is asserted for columns 0 to sync-1. DE is asserted for columns sync+back to sync+back+active-1, and px_x counts 0, 1, 2, ... across them.
- R3: Register 5 holds the active lines per field. Vertical group g (g = 0 to 3) sits at address 16+4g and holds +0 sync lines, +1 back porch lines, +2 front porch lines and +3 half-line flag in bit 0. With the flag clear, VSYNC covers lines 0 to sync-1 from column 0. DE lines start at line sync+back, and px_y counts from 0 on the first of them.
- R4: With the half-line flag set, VSYNC rises at column floor(line_length/2) of line 0 and falls at that column of line sync. It still lasts sync lines.
- R5: Control bit 2 selects interlace and bit 3 selects stereo. The field order is: neither gives 0,0,...; interlace gives 0,1,0,1; stereo gives 0,2,0,2; both give 0,1,2,3 and then repeat. Each new run starts at field 0.
- R6: field_o gives the current field as 0 left-odd, 1 left-even, 2 right-odd, 3 right-even. right_o equals field bit 1 and even_o equals field bit 0.
- R7: Control bits 4, 5 and 6 invert HSYNC, VSYNC and DE respectively. A bit value of 0 gives an active-high output.
- R8: sof_o is high for exactly one clock, on the first DE pixel of each field (px_x = 0, px_y = 0).
- R9: Horizontal values, active height, mode bits and the field's vertical group are captured at each field start. A write during a field takes effect only from the next field.
- R10: Each field uses its own vertical group. A field lasts line_length × (sync + back + active + front lines) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | CNT_W | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| px_x | output | CNT_W | Column inside the active area, 0 outside DE |
| px_y | output | CNT_W | Line inside the active area of the field, 0 outside DE |
| field_o | output | 2 | Current field index |
| right_o | output | 1 | Right-eye field |
| even_o | output | 1 | Even field |
| sof_o | output | 1 | First active pixel of a field |

## Verification
The embedded properties assume that the captured line length and field length are each at least two clocks. They also assume each field has at least one active pixel, so the column counter always has a range to stay within and sof_o cannot repeat on back-to-back cycles. The stimulus keeps to this. It writes every timing register while the soft reset bit holds the generator idle, and it uses small non-zero porch, sync and active values. The only timing writes made while running are ones meant to test the next-field capture rule.

// File: rtl/field_timing_gen.sv
module field_timing_gen #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [4:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [CNT_W-1:0] px_x,
  output logic [CNT_W-1:0] px_y,
  output logic [1:0]       field_o,
  output logic             right_o,
  output logic             even_o,
  output logic             sof_o
);
  localparam int SW = CNT_W + 2;
  localparam logic [SW-1:0] ONE = SW'(1);

  logic [6:0]       ctl_q;
  logic [CNT_W-1:0] hsw_q, hbp_q, hact_q, hfp_q, vact_q;
  logic [CNT_W-1:0] vsw_q [4];
  logic [CNT_W-1:0] vbp_q [4];
  logic [CNT_W-1:0] vfp_q [4];
  logic             vhalf_q [4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= 7'h01;
      hsw_q  <= '0;
      hbp_q  <= '0;
      hact_q <= '0;
      hfp_q  <= '0;
      vact_q <= '0;
      for (int s = 0; s < 4; s++) begin
        vsw_q[s]   <= '0;
        vbp_q[s]   <= '0;
        vfp_q[s]   <= '0;
        vhalf_q[s] <= 1'b0;
      end
    end else if (cfg_we) begin
      if (cfg_addr[4]) begin
        case (cfg_addr[1:0])
          2'd0:    vsw_q[cfg_addr[3:2]]   <= cfg_wdata;
          2'd1:    vbp_q[cfg_addr[3:2]]   <= cfg_wdata;
          2'd2:    vfp_q[cfg_addr[3:2]]   <= cfg_wdata;
          default: vhalf_q[cfg_addr[3:2]] <= cfg_wdata[0];
        endcase
      end else begin
        case (cfg_addr[3:0])
          4'd0:    ctl_q  <= cfg_wdata[6:0];
          4'd1:    hsw_q  <= cfg_wdata;
          4'd2:    hbp_q  <= cfg_wdata;
          4'd3:    hact_q <= cfg_wdata;
          4'd4:    hfp_q  <= cfg_wdata;
          4'd5:    vact_q <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  logic          run, started, wrap, load;
  logic [1:0]    fld, nxt, load_idx;
  logic [SW-1:0] hcnt, vcnt;
  logic [SW-1:0] hsw_s, hbp_s, hact_s, hfp_s, vact_s, vsw_s, vbp_s, vfp_s;
  logic          half_s;
  logic [SW-1:0] hde_start, hde_end, htot, half, vde_start, vde_end, vtot;

  assign run       = ctl_q[1] & ~ctl_q[0];
  assign hde_start = hsw_s + hbp_s;
  assign hde_end   = hde_start + hact_s;
  assign htot      = hde_end + hfp_s;
  assign half      = htot >> 1;
  assign vde_start = vsw_s + vbp_s;
  assign vde_end   = vde_start + vact_s;
  assign vtot      = vde_end + vfp_s;

  always_comb begin
    case ({ctl_q[3], ctl_q[2]})
      2'b00:   nxt = 2'd0;
      2'b01:   nxt = {1'b0, ~fld[0]};
      2'b10:   nxt = {~fld[1], 1'b0};
      default: nxt = fld + 2'd1;
    endcase
  end

  assign wrap     = started && (hcnt == htot - ONE) && (vcnt == vtot - ONE);
  assign load     = run && (!started || wrap);
  assign load_idx = started ? nxt : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      fld     <= 2'd0;
      hcnt    <= '0;
      vcnt    <= '0;
      hsw_s   <= '0;
      hbp_s   <= '0;
      hact_s  <= '0;
      hfp_s   <= '0;
      vact_s  <= '0;
      vsw_s   <= '0;
      vbp_s   <= '0;
      vfp_s   <= '0;
      half_s  <= 1'b0;
    end else if (!run) begin
      started <= 1'b0;
      fld     <= 2'd0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else if (load) begin
      started <= 1'b1;
      fld     <= load_idx;
      hcnt    <= '0;
      vcnt    <= '0;
      hsw_s   <= SW'(hsw_q);
      hbp_s   <= SW'(hbp_q);
      hact_s  <= SW'(hact_q);
      hfp_s   <= SW'(hfp_q);
      vact_s  <= SW'(vact_q);
      vsw_s   <= SW'(vsw_q[load_idx]);
      vbp_s   <= SW'(vbp_q[load_idx]);
      vfp_s   <= SW'(vfp_q[load_idx]);
      half_s  <= vhalf_q[load_idx];
    end else if (hcnt == htot - ONE) begin
      hcnt <= '0;
      vcnt <= vcnt + ONE;
    end else begin
      hcnt <= hcnt + ONE;
    end
  end

  logic hs_raw, vs_raw, de_raw;

  assign hs_raw = started && (hcnt < hsw_s);
  assign de_raw = started && (hcnt >= hde_start) && (hcnt < hde_end) &&
                  (vcnt >= vde_start) && (vcnt < vde_end);

  always_comb begin
    if (!half_s)
      vs_raw = vcnt < vsw_s;
    else
      vs_raw = (vsw_s != '0) &&
               ((vcnt == '0 && hcnt >= half) ||
                (vcnt != '0 && vcnt < vsw_s) ||
                (vcnt == vsw_s && hcnt < half));
    vs_raw = vs_raw & started;
  end

  assign hsync_o = hs_raw ^ ctl_q[4];
  assign vsync_o = vs_raw ^ ctl_q[5];
  assign de_o    = de_raw ^ ctl_q[6];
  assign px_x    = de_raw ? CNT_W'(hcnt - hde_start) : '0;
  assign px_y    = de_raw ? CNT_W'(vcnt - vde_start) : '0;
  assign sof_o   = de_raw && (hcnt == hde_start) && (vcnt == vde_start);
  assign field_o = fld;
  assign right_o = fld[1];
  assign even_o  = fld[0];

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !started && hcnt == '0 && vcnt == '0);

  a_r2_column_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> hcnt < htot);

  a_r2_px_step: assert property (@(posedge clk) disable iff (!rst_n)
    de_raw && $past(de_raw) && hcnt != hde_start |-> px_x - $past(px_x) == CNT_W'(1));

  a_r5_field_turns_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(started) && fld != $past(fld) |-> hcnt == '0 && vcnt == '0);

  a_r8_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |=> !sof_o);

  a_r9_shadow_stable: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(started) && !(hcnt == '0 && vcnt == '0) |-> $stable(htot) && $stable(vtot));
endmodule

// File: tb/field_timing_gen_tb.sv
module field_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic        hsync_o, vsync_o, de_o, right_o, even_o, sof_o;
  logic [11:0] px_x, px_y;
  logic [1:0]  field_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  field_timing_gen #(.CNT_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .px_x(px_x), .px_y(px_y),
    .field_o(field_o), .right_o(right_o), .even_o(even_o), .sof_o(sof_o)
  );

  // {stereo, interlace, f3, f2, f1, f0}
  localparam logic [9:0] MODES [4] = '{
    10'b00_00_00_00_00,
    10'b01_01_00_01_00,
    10'b10_10_00_10_00,
    10'b11_11_10_01_00
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = a[4:0];
    cfg_wdata = d[11:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic restart(input int ctl);
    wr(0, ctl | 1);
    wr(0, ctl);
  endtask

  task automatic wait_sof(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sof_o && n < 2000);
    if (!sof_o) chk("R8 sof missing", 0, 1);
  endtask

  task automatic vs_measure(output int to_sof, output int hi);
    logic prev;
    int n;
    prev = 1'b1;
    n = 0;
    while (!(vsync_o && !prev) && n < 2000) begin
      prev = vsync_o;
      @(negedge clk);
      n++;
    end
    to_sof = 0;
    hi = 1;
    while (!sof_o && to_sof < 2000) begin
      @(negedge clk);
      to_sof++;
      if (vsync_o) hi++;
    end
  endtask

  task automatic de_run(output int len);
    logic prev;
    int n;
    prev = 1'b1;
    n = 0;
    while (!(de_o && !prev) && n < 2000) begin
      prev = de_o;
      @(negedge clk);
      n++;
    end
    len = 1;
    n = 0;
    while (n < 2000) begin
      @(negedge clk);
      n++;
      if (de_o) len++;
      else break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, to_sof, hi, len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset hsync", hsync_o, 0);
    chk("R1 reset vsync", vsync_o, 0);
    chk("R1 reset de", de_o, 0);
    chk("R1 reset sof", sof_o, 0);
    chk("R1 reset px_x", px_x, 0);
    chk("R1 reset field", field_o, 0);

    // line: 2 sync, 3 back, 4 active, 1 front = 10 clocks; field g: 1,1,2,1+g lines
    wr(1, 2); wr(2, 3); wr(3, 4); wr(4, 1); wr(5, 2);
    for (int g = 0; g < 4; g++) begin
      wr(16 + 4*g, 1);
      wr(17 + 4*g, 1);
      wr(18 + 4*g, 1 + g);
      wr(19 + 4*g, 0);
    end
    repeat (20) @(negedge clk);
    chk("R1 held under soft reset", de_o | hsync_o | vsync_o, 0);

    for (int r = 0; r < 4; r++) begin
      logic [9:0] e;
      e = MODES[r];
      restart((int'(e[9]) << 3) | (int'(e[8]) << 2) | 2);
      wait_sof(n);
      for (int i = 0; i < 4; i++) begin
        int f;
        f = int'(e[2*i +: 2]);
        chk("R5 field order", field_o, f);
        chk("R6 right flag", right_o, f >> 1);
        chk("R6 even flag", even_o, f & 1);
        wait_sof(n);
        chk("R10 field length", n, (5 + f) * 10);
      end
    end

    restart(2);
    wait_sof(n);
    for (int k = 0; k < 15; k++) begin
      int pos, line, exp_de;
      pos = (5 + k) % 10;
      line = (k < 5) ? 2 : 3;
      exp_de = (pos >= 5 && pos < 9) ? 1 : 0;
      chk("R2 de column", de_o, exp_de);
      chk("R2 hsync column", hsync_o, (pos < 2) ? 1 : 0);
      chk("R3 vsync off in active", vsync_o, 0);
      chk("R8 sof single", sof_o, (k == 0) ? 1 : 0);
      if (exp_de == 1) begin
        chk("R2 px_x", px_x, pos - 5);
        chk("R3 px_y", px_y, line - 2);
      end
      @(negedge clk);
    end

    restart(2);
    vs_measure(to_sof, hi);
    chk("R3 vsync to first pixel", to_sof, 25);
    chk("R3 vsync width", hi, 10);

    wr(19, 1);
    restart(2);
    vs_measure(to_sof, hi);
    chk("R4 half-line vsync to first pixel", to_sof, 20);
    chk("R4 half-line vsync width", hi, 10);
    wr(19, 0);

    restart(2);
    wait_sof(n);
    wr(3, 6);
    de_run(len);
    chk("R9 width held mid field", len, 4);
    wait_sof(n);
    len = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (de_o) len++;
      else break;
    end
    chk("R9 width after field start", len, 6);
    wr(3, 4);

    wr(0, 32'h73);
    chk("R7 inverted idle hsync", hsync_o, 1);
    chk("R7 inverted idle vsync", vsync_o, 1);
    chk("R7 inverted idle de", de_o, 1);
    wr(0, 32'h72);
    wait_sof(n);
    chk("R7 inverted active de", de_o, 0);
    chk("R7 inverted hsync inactive", hsync_o, 1);
    chk("R7 inverted vsync inactive", vsync_o, 1);

    restart(2);
    wait_sof(n);
    wr(0, 3);
    @(negedge clk);
    chk("R1 soft reset de", de_o, 0);
    chk("R1 soft reset px_x", px_x, 0);
    chk("R1 soft reset sof", sof_o, 0);
    repeat (30) @(negedge clk);
    chk("R1 soft reset stays idle", de_o | hsync_o | vsync_o, 0);

    restart(32'h0E);
    wait_sof(n);
    wait_sof(n);
    chk("R5 second field interlaced stereo", field_o, 1);
    wr(0, 32'h0C);
    @(negedge clk);
    chk("R1 enable clear field", field_o, 0);
    chk("R1 enable clear de", de_o, 0);
    chk("R1 enable clear hsync", hsync_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule